// File: doc/BRIEF.md
# SDRAM Bank Precharge Tracker

This block sits between a memory scheduler and the command pins of a four-bank SDRAM. It records, for each bank, whether a row is open, and it turns scheduler requests (activate, read, write, precharge) into registered command-pin patterns together with the A10 and bank-address lines. A precharge may close one bank or, with the all-banks flag, every bank at once. After a bank is closed, its own down-counter blocks a new activate to that bank until the row-precharge time has passed.

The scheduler presents one request per cycle. An activate that arrives too early is stalled: `req_ready` drops, and the scheduler holds the request until it is accepted. A request that can never be legal in the present state is dropped with a one-cycle error pulse. Such requests are a read or write to a closed bank, or an activate to a bank that is already open. Refresh, mode programming, row and column addressing, and the data path are handled elsewhere.

Top module: `bank_precharge_tracker`

## Requirements
- R1: After synchronous reset, every bank is idle with no pending precharge time, the pins show NOP, `req_err` is low, and an activate to any bank is accepted in the first cycle after reset.
- R2: `req_op` encodes 0 = activate, 1 = read, 2 = write, 3 = precharge. An accepted request drives its command on the pins in the cycle after the clock edge that samples it. {cs_n, ras_n, cas_n, we_n} is L,H,H,H for NOP, L,L,H,H for activate, L,H,L,H for read, L,H,L,L for write and L,L,H,L for precharge. When no command is issued, A10 and BA are 0. An activate drives A10 low and BA to the bank.
- R3: A precharge with `req_all` low drives A10 low and BA equal to `req_bank`, and it closes only that bank.
- R4: A precharge with `req_all` high drives A10 high and BA as 00, whatever `req_bank` holds, and it closes all four banks.
- R5: If a precharge to a bank is accepted at edge 0, an activate to that bank is stalled at edges 1 to TRP_CYCLES-1 and accepted at edge TRP_CYCLES. A stalled activate sees `req_ready` low, produces NOP and no error, and changes no state.
- R6: A read or write to an idle bank is not issued. The pins show NOP and `req_err` is high for one cycle.
- R7: An activate to a bank that is already open and has no pending precharge time is not issued. The pins show NOP and `req_err` pulses high.
- R8: A precharge to a bank that is already idle is issued normally and restarts that bank's precharge time in full.
- R9: A read or write to an open bank is issued with A10 low and BA equal to the bank, and the bank stays open.
- R10: Precharge time pending on one bank never stalls an activate to a different bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Request kind (0 act, 1 read, 2 write, 3 precharge) |
| req_bank | input | 2 | Target bank |
| req_all | input | 1 | For a precharge, close every bank |
| req_ready | output | 1 | Low while an activate is held back by precharge time |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | All-banks select during precharge |
| sd_ba | output | 2 | Bank address |
| req_err | output | 1 | One-cycle pulse for a dropped illegal request |

## Verification
The bench checks the stall boundary for every bank, after both single-bank and all-bank precharges. A counter loaded one value off would release the activate a cycle early or late, and the accepted-edge count would show it. It checks that a precharge to an idle bank restarts the wait; a design that skipped the reload would accept the next activate at once. It checks that an all-bank precharge drives BA to 00 even when `req_bank` is nonzero. A long pseudo-random request stream is compared with an arithmetic model of cycles since precharge. That stream exposes errors or issued commands on closed banks, missing errors on double activates, and gating that leaks across banks.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } req_op_e;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } sdram_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_grp_t;

    typedef struct packed {
        sdram_cmd_e        cmd;
        logic              a10;
        logic [BANK_W-1:0] ba;
        logic              err;
    } issue_t;

    function automatic pin_grp_t encode_cmd(sdram_cmd_e c);
        pin_grp_t p;
        case (c)
            CMD_ACT: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            CMD_RD:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            CMD_WR:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
            CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bank_slot.sv
module bank_slot #(
    parameter int TRP   = 3,
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pre_hit,
    input  logic act_hit,
    output logic is_open,
    output logic busy
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TRP - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            cnt     <= '0;
        end else if (pre_hit) begin
            is_open <= 1'b0;
            cnt     <= RELOAD;
        end else begin
            if (act_hit) is_open <= 1'b1;
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R5 R7
    act_legal_chk: assert property (@(posedge clk) disable iff (rst)
        act_hit |-> (!busy && !is_open));

    // R3
    pre_close_chk: assert property (@(posedge clk) disable iff (rst)
        pre_hit |=> !is_open);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !is_open);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        pre_hit |=> (busy == (TRP > 1)));

endmodule

// File: rtl/req_check.sv
module req_check
    import bpt_pkg::*;
(
    input  logic                 valid,
    input  logic [1:0]           op,
    input  logic [BANK_W-1:0]    bank,
    input  logic                 all_banks,
    input  logic [NUM_BANKS-1:0] open_vec,
    input  logic [NUM_BANKS-1:0] busy_vec,
    output logic                 ready,
    output issue_t               nxt,
    output logic [NUM_BANKS-1:0] pre_mask,
    output logic [NUM_BANKS-1:0] act_mask
);
    req_op_e                op_e;
    logic [NUM_BANKS-1:0]   bank_bit;

    assign op_e     = req_op_e'(op);
    assign bank_bit = NUM_BANKS'(1) << bank;

    always_comb begin
        ready    = 1'b1;
        nxt      = '{cmd: CMD_NOP, a10: 1'b0, ba: '0, err: 1'b0};
        pre_mask = '0;
        act_mask = '0;
        if (valid) begin
            case (op_e)
                OP_PRE: begin
                    nxt.cmd = CMD_PRE;
                    if (all_banks) begin
                        nxt.a10  = 1'b1;
                        pre_mask = '1;
                    end else begin
                        nxt.ba   = bank;
                        pre_mask = bank_bit;
                    end
                end
                OP_ACT: begin
                    if (busy_vec[bank]) begin
                        ready = 1'b0;
                    end else if (open_vec[bank]) begin
                        nxt.err = 1'b1;
                    end else begin
                        nxt.cmd  = CMD_ACT;
                        nxt.ba   = bank;
                        act_mask = bank_bit;
                    end
                end
                default: begin
                    if (open_vec[bank]) begin
                        nxt.cmd = (op_e == OP_RD) ? CMD_RD : CMD_WR;
                        nxt.ba  = bank;
                    end else begin
                        nxt.err = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cmd_out_stage.sv
module cmd_out_stage
    import bpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  issue_t            nxt,
    output pin_grp_t          pins,
    output logic              a10,
    output logic [BANK_W-1:0] ba,
    output logic              err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= encode_cmd(CMD_NOP);
            a10  <= 1'b0;
            ba   <= '0;
            err  <= 1'b0;
        end else begin
            pins <= encode_cmd(nxt.cmd);
            a10  <= nxt.a10;
            ba   <= nxt.ba;
            err  <= nxt.err;
        end
    end

    // R6
    err_nop_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (pins == encode_cmd(CMD_NOP)));

    // R4
    all_pre_ba_chk: assert property (@(posedge clk) disable iff (rst)
        (a10 && pins == encode_cmd(CMD_PRE)) |-> (ba == '0));

endmodule

// File: rtl/bank_precharge_tracker.sv
module bank_precharge_tracker
    import bpt_pkg::*;
#(
    parameter int TRP_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_all,
    output logic              req_ready,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_a10,
    output logic [BANK_W-1:0] sd_ba,
    output logic              req_err
);
    localparam int CNT_W = (TRP_CYCLES > 1) ? $clog2(TRP_CYCLES) : 1;

    logic [NUM_BANKS-1:0] open_vec, busy_vec, pre_mask, act_mask;
    issue_t               nxt;
    pin_grp_t             pins;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_slot #(.TRP(TRP_CYCLES), .CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .pre_hit (pre_mask[g]),
            .act_hit (act_mask[g]),
            .is_open (open_vec[g]),
            .busy    (busy_vec[g])
        );
    end

    req_check u_chk (
        .valid     (req_valid),
        .op        (req_op),
        .bank      (req_bank),
        .all_banks (req_all),
        .open_vec  (open_vec),
        .busy_vec  (busy_vec),
        .ready     (req_ready),
        .nxt       (nxt),
        .pre_mask  (pre_mask),
        .act_mask  (act_mask)
    );

    cmd_out_stage u_out (
        .clk  (clk),
        .rst  (rst),
        .nxt  (nxt),
        .pins (pins),
        .a10  (sd_a10),
        .ba   (sd_ba),
        .err  (req_err)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    // R9
    rw_open_chk: assert property (@(posedge clk) disable iff (rst)
        (nxt.cmd == CMD_RD || nxt.cmd == CMD_WR) |-> open_vec[nxt.ba]);

    // R5
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (pins == encode_cmd(CMD_NOP) && !req_err));

endmodule

// File: tb/bank_precharge_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_precharge_tracker_tb_top;
    localparam int TRP = 4;
    localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                           P_WR = 4'b0100, P_PRE = 4'b0010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [1:0] req_bank = '0;
    logic req_all = 1'b0;
    logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, req_err;
    logic [1:0] sd_ba;

    int n_cmp = 0;
    int n_bad = 0;
    int since [4];
    bit open_m [4];
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    bank_precharge_tracker #(.TRP_CYCLES(TRP)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_all(req_all), .req_ready(req_ready),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_a10(sd_a10), .sd_ba(sd_ba), .req_err(req_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [8:0] a, input logic [8:0] e);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %b expected %b (ready,err,cs,ras,cas,we,a10,ba)", tag, a, e);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] op, input logic [1:0] bk,
                        input bit all, output logic [8:0] got);
        @(negedge clk);
        req_valid = v; req_op = op; req_bank = bk; req_all = all;
        #1 got[8] = req_ready;
        @(posedge clk);
        #1 got[7:0] = {req_err, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_ba};
        req_valid = 1'b0;
    endtask

    task automatic mstep(input bit v, input logic [1:0] op, input logic [1:0] bk,
                         input bit all, input string force_tag, output logic [8:0] got);
        bit rdy = 1'b1, err = 1'b0, a10 = 1'b0;
        logic [3:0] pins = P_NOP;
        logic [1:0] ba = 2'b00;
        string tag = "R2";
        logic [8:0] e;
        if (v) begin
            case (op)
                2'd3: begin
                    pins = P_PRE;
                    if (all) begin a10 = 1'b1; tag = "R4"; end
                    else begin ba = bk; tag = open_m[bk] ? "R3" : "R8"; end
                end
                2'd0: begin
                    if (since[bk] < TRP) begin rdy = 1'b0; tag = "R5"; end
                    else if (open_m[bk]) begin err = 1'b1; tag = "R7"; end
                    else begin pins = P_ACT; ba = bk; end
                end
                default: begin
                    if (open_m[bk]) begin pins = (op == 2'd1) ? P_RD : P_WR; ba = bk; tag = "R9"; end
                    else begin err = 1'b1; tag = "R6"; end
                end
            endcase
        end
        if (force_tag != "") tag = force_tag;
        step(v, op, bk, all, got);
        e = {rdy, err, pins, a10, ba};
        chk(got == e, tag, got, e);
        if (v && rdy) begin
            if (op == 2'd3) begin
                for (int b = 0; b < 4; b++)
                    if (all || b == int'(bk)) begin open_m[b] = 1'b0; since[b] = 0; end
            end else if (op == 2'd0 && !err) begin
                open_m[bk] = 1'b1;
            end
        end
        for (int b = 0; b < 4; b++) if (since[b] < TRP) since[b]++;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired, got running expected finished");
        report();
    end

    initial begin
        logic [8:0] got;
        int n;
        for (int b = 0; b < 4; b++) begin since[b] = TRP; open_m[b] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: idle pins straight after reset
        #1 chk({req_err, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_ba} == {1'b0, P_NOP, 3'b000},
               "R1", {1'b1, req_err, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_ba},
               {1'b1, 1'b0, P_NOP, 3'b000});
        mstep(1, 2'd0, 2'd2, 0, "R1", got);
        mstep(1, 2'd2, 2'd2, 0, "", got);
        mstep(1, 2'd1, 2'd1, 0, "", got);
        mstep(1, 2'd0, 2'd2, 0, "", got);
        // R4: all-bank precharge with a nonzero bank field
        mstep(1, 2'd3, 2'd3, 1, "R4", got);
        // R5 / R8: stall boundary for every bank and both precharge kinds
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 2; a++) begin
                mstep(1, 2'd3, 2'(b), bit'(a), "", got);
                n = 0;
                do begin
                    mstep(1, 2'd0, 2'(b), 0, "R5", got);
                    n++;
                end while (!got[8] && n < 12);
                chk(n == TRP, "R5", 9'(n), 9'(TRP));
            end
        end
        // R10: bank 3 is not gated by a fresh precharge of bank 2
        repeat (TRP) mstep(0, 2'd0, 2'd0, 0, "", got);
        mstep(1, 2'd3, 2'd2, 0, "", got);
        mstep(1, 2'd3, 2'd3, 0, "", got);
        repeat (TRP) mstep(0, 2'd0, 2'd0, 0, "", got);
        mstep(1, 2'd3, 2'd2, 0, "", got);
        mstep(1, 2'd0, 2'd3, 0, "R10", got);
        // pseudo-random stream checked against the model
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mstep(lfsr[2:0] != 3'b000, lfsr[4:3], lfsr[6:5], lfsr[11:7] == 5'd0, "", got);
        end
        report();
    end

endmodule